// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This unit executes the first group of operate-class microinstructions against a 12-bit accumulator and its 1-bit link. One instruction word may pack several micro-operations: clearing, complementing, incrementing and one rotate or half-word swap. All of them are applied in a fixed order within a single execution step. The unit also reports whether the word belongs to this group at all. Words outside the group pass the accumulator and link through unchanged.

The caller presents the word, the current accumulator and the link on a valid/ready input stream. The result leaves on a valid/ready output stream through one register stage. A transfer happens on a clock edge where valid and ready are both high. The input is ready whenever the output register is empty or is being drained in the same cycle. While the consumer holds output ready low, the pending result and all its fields stay frozen. No new word is accepted until that result leaves.

Bits are numbered here as vector positions, with 11 the most significant bit.

Top module: `opr1_unit`

## Requirements
- R1: `out_member` is 1 exactly when the accepted word has `in_inst[11:9]` = 3'b111 and `in_inst[8]` = 0.
- R2: For a word outside the group, `out_acc` and `out_link` equal the accepted accumulator and link.
- R3: `in_inst[7]` clears the accumulator and `in_inst[6]` clears the link. Both act before every other micro-operation.
- R4: `in_inst[5]` complements the accumulator and `in_inst[4]` complements the link. Both act after the clears.
- R5: `in_inst[0]` adds one to the accumulator after the complements. A carry out of bit 11 complements the link.
- R6: With `in_inst[3:1]` = 3'b100, the 13-bit ring {link, accumulator} rotates right by one after the increment. Accumulator bit 0 goes to the link, and the link goes to accumulator bit 11.
- R7: With `in_inst[3:1]` = 3'b010, the ring rotates left by one. Accumulator bit 11 goes to the link, and the link goes to accumulator bit 0.
- R8: With `in_inst[3:1]` = 3'b101 the ring rotates right by two. With `in_inst[3:1]` = 3'b011 it rotates left by two.
- R9: When `in_inst[3]` and `in_inst[2]` are both 1, no rotate occurs and the post-increment values are delivered.
- R10: With `in_inst[3:1]` = 3'b001, the two 6-bit halves of the post-increment accumulator are exchanged and the link is not changed.
- R11: `out_valid` rises on the edge after an accepted word. `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the outputs hold steady.
- R12: During reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_inst | input | 12 | Instruction word |
| in_acc | input | 12 | Current accumulator |
| in_link | input | 1 | Current link |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_acc | output | 12 | Updated accumulator |
| out_link | output | 1 | Updated link |
| out_member | output | 1 | Word belonged to this operate group |

## Verification
The hardest interaction to reach is the chaining of stages. In that case a complement, the increment's carry into the link and a two-step rotate all touch the same bits, so an error in stage order only shows up for particular operand values. The bench reaches it by sweeping all 256 settings of the low eight word bits, each against several random accumulator and link values and against the all-ones accumulator, which forces the carry. A separate sequence holds the output stream stalled while a second word waits, then releases it.

// File: rtl/opr1_pkg.sv
package opr1_pkg;
  localparam int unsigned INST_W = 12;

  // vector positions of the fields inside the instruction word
  localparam int unsigned P_GRP_HI  = 11;
  localparam int unsigned P_GRP_LO  = 9;
  localparam int unsigned P_SEL     = 8;
  localparam int unsigned P_CLR_ACC = 7;
  localparam int unsigned P_CLR_LNK = 6;
  localparam int unsigned P_INV_ACC = 5;
  localparam int unsigned P_INV_LNK = 4;
  localparam int unsigned P_ROT_R   = 3;
  localparam int unsigned P_ROT_L   = 2;
  localparam int unsigned P_TWICE   = 1;
  localparam int unsigned P_INC     = 0;

  typedef enum logic [2:0] {
    SH_NONE = 3'd0,
    SH_R1   = 3'd1,
    SH_L1   = 3'd2,
    SH_R2   = 3'd3,
    SH_L2   = 3'd4,
    SH_SWAP = 3'd5
  } shift_op_t;

  typedef struct packed {
    logic      member;
    logic      clr_acc;
    logic      clr_lnk;
    logic      inv_acc;
    logic      inv_lnk;
    logic      inc;
    shift_op_t shift;
  } opr1_ctl_t;
endpackage

// File: rtl/opr1_decode.sv
module opr1_decode
  import opr1_pkg::*;
(
  input  logic [INST_W-1:0] inst,
  output opr1_ctl_t         ctl
);
  logic [2:0] rot_bits;

  always_comb begin
    ctl         = '0;
    ctl.member  = (&inst[P_GRP_HI:P_GRP_LO]) & ~inst[P_SEL];
    ctl.clr_acc = inst[P_CLR_ACC];
    ctl.clr_lnk = inst[P_CLR_LNK];
    ctl.inv_acc = inst[P_INV_ACC];
    ctl.inv_lnk = inst[P_INV_LNK];
    ctl.inc     = inst[P_INC];
    rot_bits    = {inst[P_ROT_R], inst[P_ROT_L], inst[P_TWICE]};
    unique case (rot_bits)
      3'b001:  ctl.shift = SH_SWAP;
      3'b100:  ctl.shift = SH_R1;
      3'b101:  ctl.shift = SH_R2;
      3'b010:  ctl.shift = SH_L1;
      3'b011:  ctl.shift = SH_L2;
      default: ctl.shift = SH_NONE; // 000, 110, 111
    endcase
  end
endmodule

// File: rtl/opr1_arith.sv
module opr1_arith
  import opr1_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  opr1_ctl_t    ctl,
  input  logic [W-1:0] acc_i,
  input  logic         lnk_i,
  output logic [W-1:0] acc_o,
  output logic         lnk_o
);
  logic [W-1:0] acc_clr, acc_inv;
  logic         lnk_clr, lnk_inv;
  logic [W:0]   sum;

  always_comb begin
    acc_clr = ctl.clr_acc ? '0 : acc_i;
    lnk_clr = ctl.clr_lnk ? 1'b0 : lnk_i;
    acc_inv = ctl.inv_acc ? ~acc_clr : acc_clr;
    lnk_inv = ctl.inv_lnk ? ~lnk_clr : lnk_clr;
    sum     = {1'b0, acc_inv} + {{W{1'b0}}, ctl.inc};
    acc_o   = sum[W-1:0];
    lnk_o   = lnk_inv ^ sum[W];
  end
endmodule

// File: rtl/opr1_shift.sv
module opr1_shift
  import opr1_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  shift_op_t    op,
  input  logic [W-1:0] acc_i,
  input  logic         lnk_i,
  output logic [W-1:0] acc_o,
  output logic         lnk_o
);
  localparam int unsigned RING = W + 1;
  localparam int unsigned HALF = W / 2;

  logic [RING-1:0] ring;
  logic [RING-1:0] stage [0:2];
  logic [RING-1:0] left  [0:2];

  assign ring     = {lnk_i, acc_i};
  assign stage[0] = ring;
  assign left[0]  = ring;

  // two chained single-step rotators in each direction
  for (genvar s = 1; s < 3; s++) begin : g_step
    assign stage[s] = {stage[s-1][0], stage[s-1][RING-1:1]};
    assign left[s]  = {left[s-1][RING-2:0], left[s-1][RING-1]};
  end

  logic [RING-1:0] res;

  always_comb begin
    unique case (op)
      SH_R1:   res = stage[1];
      SH_R2:   res = stage[2];
      SH_L1:   res = left[1];
      SH_L2:   res = left[2];
      SH_SWAP: res = {lnk_i, acc_i[HALF-1:0], acc_i[W-1:HALF]};
      default: res = ring;
    endcase
    lnk_o = res[RING-1];
    acc_o = res[W-1:0];
  end
endmodule

// File: rtl/opr1_unit.sv
module opr1_unit
  import opr1_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INST_W-1:0] in_inst,
  input  logic [W-1:0]      in_acc,
  input  logic              in_link,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_acc,
  output logic              out_link,
  output logic              out_member
);
  opr1_ctl_t    ctl;
  logic [W-1:0] acc_a, acc_s, acc_n;
  logic         lnk_a, lnk_s, lnk_n;
  logic         take;

  opr1_decode u_dec (
    .inst (in_inst),
    .ctl  (ctl)
  );

  opr1_arith #(.W(W)) u_arith (
    .ctl   (ctl),
    .acc_i (in_acc),
    .lnk_i (in_link),
    .acc_o (acc_a),
    .lnk_o (lnk_a)
  );

  opr1_shift #(.W(W)) u_shift (
    .op    (ctl.shift),
    .acc_i (acc_a),
    .lnk_i (lnk_a),
    .acc_o (acc_s),
    .lnk_o (lnk_s)
  );

  assign acc_n    = ctl.member ? acc_s : in_acc;
  assign lnk_n    = ctl.member ? lnk_s : in_link;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_acc    <= '0;
      out_link   <= 1'b0;
      out_member <= 1'b0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_acc    <= acc_n;
        out_link   <= lnk_n;
        out_member <= ctl.member;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/opr1_unit_chk.sv
module opr1_unit_chk #(
  parameter int unsigned W = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [11:0]   in_inst,
  input logic [W-1:0]  in_acc,
  input logic          in_link,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_acc,
  input logic          out_link,
  input logic          out_member
);
  logic acc_t;
  assign acc_t = in_valid & in_ready;

  p_reset_empty_r12: assert property (@(posedge clk) rst |=> !out_valid);

  p_accept_r11: assert property (@(posedge clk) disable iff (rst)
    acc_t |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_acc) && $stable(out_link) && $stable(out_member)));

  p_ready_r11: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready);

  p_member_r1: assert property (@(posedge clk) disable iff (rst)
    acc_t |=> (out_member == ($past(in_inst[11:8]) == 4'b1110)));

  p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_t && in_inst[11:8] != 4'b1110) |=>
      (out_acc == $past(in_acc) && out_link == $past(in_link)));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_t && in_inst == 12'b1110_1100_0000) |=>
      (out_acc == '0 && !out_link));
endmodule

bind opr1_unit opr1_unit_chk #(.W(W)) u_chk (.*);

// File: tb/opr1_unit_bench.sv
module opr1_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [11:0] in_inst, in_acc;
  logic        in_link;
  logic        out_valid, out_ready;
  logic [11:0] out_acc;
  logic        out_link, out_member;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opr1_unit u_opr1_unit (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_inst(in_inst), .in_acc(in_acc), .in_link(in_link),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_acc(out_acc), .out_link(out_link), .out_member(out_member)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference: returns {link, acc} as a 13-bit value
  function automatic int model(input int w, input int a, input int l);
    int v, s;
    if ((w >> 8) != 'he) return (l << 12) | a;
    if ((w >> 7) & 1) a = 0;
    if ((w >> 6) & 1) l = 0;
    if ((w >> 5) & 1) a = 4095 - a;
    if ((w >> 4) & 1) l = 1 - l;
    if (w & 1) begin
      a = a + 1;
      if (a == 4096) begin a = 0; l = 1 - l; end
    end
    v = l * 4096 + a;
    s = (w >> 1) & 7;
    case (s)
      'b100: v = ((v >> 1) | (v << 12)) & 'h1fff;
      'b101: v = ((v >> 2) | (v << 11)) & 'h1fff;
      'b010: v = ((v << 1) | (v >> 12)) & 'h1fff;
      'b011: v = ((v << 2) | (v >> 11)) & 'h1fff;
      'b001: v = l * 4096 + ((a % 64) * 64) + (a / 64);
      default: ;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input int w);
    int s;
    s = (w >> 1) & 7;
    if ((w >> 8) != 'he) return "R2";
    if (s >= 6) return "R9";
    if (s == 1) return "R10";
    if (s == 3 || s == 5) return "R8";
    if (s == 2) return "R7";
    if (s == 4) return "R6";
    if (w & 1) return "R5";
    if ((w >> 4) & 3) return "R4";
    if ((w >> 6) & 3) return "R3";
    return "R1";
  endfunction

  task automatic send(input int w, input int a, input int l);
    int exp;
    @(negedge clk);
    in_inst = w[11:0]; in_acc = a[11:0]; in_link = l[0]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(w, a, l);
    check(tag_of(w), {19'd0, out_link, out_acc}, exp);
    check("R1", int'(out_member), int'((w >> 8) == 'he));
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_inst = '0; in_acc = '0; in_link = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", int'(out_valid), 0);
    check("R12", int'(in_ready), 1);
    rst = 1'b0;

    // directed corner cases
    send('he01, 'hfff, 0);   // increment wraps, link flips (R5)
    send('he01, 'hfff, 1);
    send('he31, 'h000, 0);   // complement then increment (R4, R5)
    send('hec0, 'h5a5, 1);   // both clears (R3)
    send('he03, 'h001, 0);   // swap after increment (R10)
    send('he0e, 'h800, 1);   // both rotate bits, no rotate (R9)

    // full sweep of the low byte against varied operands
    for (int w = 0; w < 256; w++) begin
      for (int k = 0; k < 6; k++)
        send('he00 | w, $urandom % 4096, $urandom % 2);
      send('he00 | w, 'hfff, 1);
    end

    // words outside the group (R2)
    for (int g = 0; g < 16; g++)
      if (g != 'he) send((g << 8) | ($urandom % 256), $urandom % 4096, $urandom % 2);

    // back-pressure (R11)
    send('he80, 'h123, 1);
    out_ready = 1'b0;
    @(negedge clk);
    in_inst = 12'he01; in_acc = 12'h00f; in_link = 1'b0; in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R11", int'(in_ready), 0);
      check("R11", {19'd0, out_link, out_acc}, 'h1000);
      check("R11", int'(out_valid), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", {19'd0, out_link, out_acc}, 'h010);
    @(negedge clk);
    check("R11", int'(out_valid), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule